// File: doc/BRIEF.md
# SDRAM Auto-Precharge Interrupt Tracker

This block sits beside an SDRAM command sequencer and follows the commands it issues: bank activation, reads and writes with or without automatic precharge, and idle cycles. For each of four banks it keeps a small state machine (idle, page open, write burst, read burst, write recovery, precharging) with its own down-counter. From these it derives a ready flag per bank, a strobe for every write-data beat with its bank and column, and the cycle, bank and column of every returning read beat.

The case it handles with care is a write burst with automatic precharge that is cut short by a read or write to another bank. The cut burst stops at once. Its write-recovery interval is counted from the cycle of the interrupting command, not from where the burst would have ended. Precharge follows that interval, and the bank becomes ready again once precharge completes. The sequencer uses the ready flags to decide when a bank may be reopened. It uses the strobes to time write data and read capture. Commands that break the bank rules are flagged and have no effect.

Top module: `sdram_ap_tracker`

## Requirements
- R1: After reset every `bank_ready` bit is 1, every `bank_pre` bit is 0, and `wr_valid`, `rd_valid` and `cmd_err` are 0.
- R2: `cmd_code` is encoded as 0 idle, 1 open bank, 2 read, 3 write. `cmd_err` goes high in the same cycle when an open targets a bank that is not ready, or when a read or write targets a bank that is not page-open (idle, bursting, in write recovery or precharging). A flagged command changes no state and produces no beat.
- R3: A write accepted in cycle c gives `wr_valid` in cycles c to c+BL-1, with `wr_bank` set to the target. Beat i carries column (base − base mod BL) + ((base mod BL) + i) mod BL.
- R4: An accepted read or write to another bank in cycle c ends any burst in progress. The old burst's last beat is in cycle c-1, and cycle c carries only the new command's beat.
- R5: After a write with auto precharge, write recovery lasts T_DPL cycles counted from an anchor cycle. The anchor is the interrupting command's cycle, or the last beat's cycle if the burst ran to its end. `bank_pre` is then high for T_RP cycles, starting at anchor+T_DPL+1.
- R6: `bank_ready` rises in the cycle after the last precharge cycle. An open command in that cycle is accepted, and one a cycle earlier is flagged.
- R7: Each read beat, issued in cycle t, returns `rd_valid` in cycle t+CL with its bank and column, following the column order of R3.
- R8: A read with auto precharge has no recovery phase. `bank_pre` starts in the cycle after the last read beat.
- R9: A burst without auto precharge returns the bank to page-open, whether it ends naturally or is interrupted. The bank then accepts a new column command with no error.
- R10: An interrupting write with auto precharge runs its full BL beats. It then takes its own recovery and precharge per R5, anchored at its own last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_code | input | 2 | Command: 0 idle, 1 open bank, 2 read, 3 write |
| cmd_ap | input | 1 | Auto precharge on the read or write |
| cmd_bank | input | BANK_W | Target bank |
| cmd_col | input | COL_W | Starting column of a read or write |
| bank_ready | output | NUM_BANKS | Bank idle and may be opened |
| bank_pre | output | NUM_BANKS | Bank in internal precharge |
| cmd_err | output | 1 | Current command breaks the bank rules and is ignored |
| wr_valid | output | 1 | Write data beat in this cycle |
| wr_bank | output | BANK_W | Bank of the write beat |
| wr_col | output | COL_W | Column of the write beat |
| rd_valid | output | 1 | Read data returns in this cycle |
| rd_bank | output | BANK_W | Bank of the returning beat |
| rd_col | output | COL_W | Column of the returning beat |

## Verification
A bank stuck in the wrong state shows up within a single cycle. It either flags a legal command on `cmd_err` or accepts an illegal one. A recovery or precharge counter that is off by one shifts the `bank_pre` window and the rise of `bank_ready` by exactly that cycle, so the bench compares every cycle of each window. Beats that are truncated or extended show on `wr_valid` in the cycle of the interrupting command. On the read side they appear CL cycles later on `rd_valid`.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_e;

  typedef enum logic [2:0] {
    BK_IDLE,
    BK_ACTIVE,
    BK_BURST_WR,
    BK_BURST_RD,
    BK_WRITE_BACK,
    BK_PRECHARGE
  } bank_st_e;

  function automatic int max3(int a, int b, int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Column of beat 'beat' inside a BL-aligned wrapping block
  function automatic logic [31:0] burst_col(logic [31:0] base, int unsigned beat,
                                            int unsigned bl);
    logic [31:0] mask;
    mask = 32'(bl - 1);
    return (base & ~mask) | ((base + 32'(beat)) & mask);
  endfunction

  // State entered when a burst ends or is cut
  function automatic bank_st_e after_burst(logic was_wr, logic ap);
    if (!ap)   return BK_ACTIVE;
    if (was_wr) return BK_WRITE_BACK;
    return BK_PRECHARGE;
  endfunction

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_trk_pkg::*;
#(
  parameter int BL    = 4,
  parameter int T_DPL = 2,
  parameter int T_RP  = 3,
  parameter int CNT_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_act,
  input  logic start_rd,
  input  logic start_wr,
  input  logic start_ap,
  input  logic intr,
  output logic ready,
  output logic act,
  output logic pre,
  output logic wb,
  output logic bwr,
  output logic ap_q,
  output logic wr_beat,
  output logic rd_beat
);

  bank_st_e          st, nxt_st;
  logic [CNT_W-1:0]  cnt, nxt_cnt;
  logic              nxt_ap;

  function automatic logic [CNT_W-1:0] end_load(logic was_wr);
    return was_wr ? CNT_W'(T_DPL) : CNT_W'(T_RP);
  endfunction

  always_comb begin
    nxt_st  = st;
    nxt_cnt = cnt;
    nxt_ap  = ap_q;
    case (st)
      BK_IDLE: if (start_act) nxt_st = BK_ACTIVE;
      BK_ACTIVE: begin
        if (start_wr || start_rd) begin
          nxt_ap = start_ap;
          if (BL == 1) begin
            nxt_st  = after_burst(start_wr, start_ap);
            nxt_cnt = end_load(start_wr);
          end else begin
            nxt_st  = start_wr ? BK_BURST_WR : BK_BURST_RD;
            nxt_cnt = CNT_W'(BL - 1);
          end
        end
      end
      BK_BURST_WR, BK_BURST_RD: begin
        if (intr || cnt == CNT_W'(1)) begin
          nxt_st  = after_burst(st == BK_BURST_WR, ap_q);
          nxt_cnt = end_load(st == BK_BURST_WR);
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      BK_WRITE_BACK: begin
        if (cnt == CNT_W'(1)) begin
          nxt_st  = BK_PRECHARGE;
          nxt_cnt = CNT_W'(T_RP);
        end else begin
          nxt_cnt = cnt - CNT_W'(1);
        end
      end
      BK_PRECHARGE: begin
        if (cnt == CNT_W'(1)) nxt_st = BK_IDLE;
        else                  nxt_cnt = cnt - CNT_W'(1);
      end
      default: nxt_st = BK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= BK_IDLE;
      cnt  <= '0;
      ap_q <= 1'b0;
    end else begin
      st   <= nxt_st;
      cnt  <= nxt_cnt;
      ap_q <= nxt_ap;
    end
  end

  assign ready   = (st == BK_IDLE);
  assign act     = (st == BK_ACTIVE);
  assign pre     = (st == BK_PRECHARGE);
  assign wb      = (st == BK_WRITE_BACK);
  assign bwr     = (st == BK_BURST_WR);
  assign wr_beat = (st == BK_BURST_WR) && !intr;
  assign rd_beat = (st == BK_BURST_RD) && !intr;

endmodule

// File: rtl/sdram_rd_return.sv
module sdram_rd_return #(
  parameter int DEPTH = 3,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  logic [DEPTH-1:0] vld;
  logic [W-1:0]     dat [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      for (int i = 0; i < DEPTH; i++) dat[i] <= '0;
    end else begin
      vld[0] <= in_valid;
      dat[0] <= in_data;
      for (int i = 1; i < DEPTH; i++) begin
        vld[i] <= vld[i-1];
        dat[i] <= dat[i-1];
      end
    end
  end

  assign out_valid = vld[DEPTH-1];
  assign out_data  = dat[DEPTH-1];

endmodule

// File: rtl/sdram_ap_tracker.sv
module sdram_ap_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 10,
  parameter int BL        = 4,
  parameter int CL        = 3,
  parameter int T_DPL     = 2,
  parameter int T_RP      = 3,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cmd_code,
  input  logic                 cmd_ap,
  input  logic [BANK_W-1:0]    cmd_bank,
  input  logic [COL_W-1:0]     cmd_col,
  output logic [NUM_BANKS-1:0] bank_ready,
  output logic [NUM_BANKS-1:0] bank_pre,
  output logic                 cmd_err,
  output logic                 wr_valid,
  output logic [BANK_W-1:0]    wr_bank,
  output logic [COL_W-1:0]     wr_col,
  output logic                 rd_valid,
  output logic [BANK_W-1:0]    rd_bank,
  output logic [COL_W-1:0]     rd_col
);

  localparam int T_MAX = max3(BL, T_DPL, T_RP);
  localparam int CNT_W = $clog2(T_MAX + 1);
  localparam int RET_W = BANK_W + COL_W;

  cmd_e cmd;
  logic is_act, is_rd, is_wr, is_col, col_acc;
  logic [NUM_BANKS-1:0] bank_act, bank_wb, bank_bwr, bank_ap;
  logic [NUM_BANKS-1:0] wr_beat_vec, rd_beat_vec;
  logic [BANK_W-1:0]    wr_beat_bank, rd_beat_bank;
  logic [COL_W-1:0]     burst_col_q;
  logic                 rd_iss;
  logic [BANK_W-1:0]    rd_iss_bank;
  logic [COL_W-1:0]     rd_iss_col;

  assign cmd    = cmd_e'(cmd_code);
  assign is_act = (cmd == CMD_ACT);
  assign is_rd  = (cmd == CMD_RD);
  assign is_wr  = (cmd == CMD_WR);
  assign is_col = is_rd || is_wr;

  assign cmd_err = (is_act && !bank_ready[cmd_bank]) ||
                   (is_col && !bank_act[cmd_bank]);
  assign col_acc = is_col && !cmd_err;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic sel;
    assign sel = (cmd_bank == BANK_W'(g));
    sdram_bank_fsm #(.BL(BL), .T_DPL(T_DPL), .T_RP(T_RP), .CNT_W(CNT_W)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_act(is_act && !cmd_err && sel),
      .start_rd (is_rd && col_acc && sel),
      .start_wr (is_wr && col_acc && sel),
      .start_ap (cmd_ap),
      .intr     (col_acc && !sel),
      .ready    (bank_ready[g]),
      .act      (bank_act[g]),
      .pre      (bank_pre[g]),
      .wb       (bank_wb[g]),
      .bwr      (bank_bwr[g]),
      .ap_q     (bank_ap[g]),
      .wr_beat  (wr_beat_vec[g]),
      .rd_beat  (rd_beat_vec[g])
    );
  end

  always_comb begin
    wr_beat_bank = '0;
    rd_beat_bank = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (wr_beat_vec[b]) wr_beat_bank = BANK_W'(b);
      if (rd_beat_vec[b]) rd_beat_bank = BANK_W'(b);
    end
  end

  // Column of the next beat of the running burst
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      burst_col_q <= '0;
    else if (col_acc)
      burst_col_q <= COL_W'(burst_col(32'(cmd_col), 1, BL));
    else if (|(wr_beat_vec | rd_beat_vec))
      burst_col_q <= COL_W'(burst_col(32'(burst_col_q), 1, BL));
  end

  assign wr_valid = (is_wr && col_acc) || (|wr_beat_vec);
  assign wr_bank  = (is_wr && col_acc) ? cmd_bank : wr_beat_bank;
  assign wr_col   = (is_wr && col_acc) ? cmd_col  : burst_col_q;

  assign rd_iss      = (is_rd && col_acc) || (|rd_beat_vec);
  assign rd_iss_bank = (is_rd && col_acc) ? cmd_bank : rd_beat_bank;
  assign rd_iss_col  = (is_rd && col_acc) ? cmd_col  : burst_col_q;

  sdram_rd_return #(.DEPTH(CL), .W(RET_W)) u_ret (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rd_iss),
    .in_data  ({rd_iss_bank, rd_iss_col}),
    .out_valid(rd_valid),
    .out_data ({rd_bank, rd_col})
  );

endmodule

// File: rtl/sdram_ap_tracker_chk.sv
module sdram_ap_tracker_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int CL        = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [1:0]           cmd_code,
  input logic [BANK_W-1:0]    cmd_bank,
  input logic                 cmd_err,
  input logic [NUM_BANKS-1:0] bank_ready,
  input logic [NUM_BANKS-1:0] bank_pre,
  input logic                 rd_valid,
  input logic                 rd_iss,
  input logic                 col_acc,
  input logic [NUM_BANKS-1:0] wr_beat_vec,
  input logic [NUM_BANKS-1:0] rd_beat_vec,
  input logic [NUM_BANKS-1:0] bank_wb,
  input logic [NUM_BANKS-1:0] bank_bwr,
  input logic [NUM_BANKS-1:0] bank_ap
);

  a_r6_act_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 2'd1 && !bank_ready[cmd_bank]) |-> cmd_err);

  a_r4_new_beat_alone: assert property (@(posedge clk) disable iff (!rst_n)
    col_acc |-> (wr_beat_vec == '0 && rd_beat_vec == '0));

  a_r3_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_beat_vec | rd_beat_vec));

  a_r7_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(rd_iss, CL));

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_chk
    a_r5_cut_enters_recovery: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_bwr[b] && bank_ap[b] && col_acc && cmd_bank != BANK_W'(b)) |=> bank_wb[b]);

    a_r5_recovery_to_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bank_wb[b]) |-> bank_pre[b]);

    a_r6_ready_after_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bank_ready[b]) |-> $past(bank_pre[b]));
  end

endmodule

bind sdram_ap_tracker sdram_ap_tracker_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .CL(CL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
  .cmd_err(cmd_err), .bank_ready(bank_ready), .bank_pre(bank_pre),
  .rd_valid(rd_valid), .rd_iss(rd_iss), .col_acc(col_acc),
  .wr_beat_vec(wr_beat_vec), .rd_beat_vec(rd_beat_vec),
  .bank_wb(bank_wb), .bank_bwr(bank_bwr), .bank_ap(bank_ap)
);

// File: tb/sdram_ap_tracker_test.sv
module sdram_ap_tracker_test;

  localparam int NB = 4, COL_W = 10, BL = 4, CL = 3, T_DPL = 2, T_RP = 3;
  localparam int NC = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic cmd_ap = 1'b0;
  logic [1:0] cmd_bank = 2'd0;
  logic [COL_W-1:0] cmd_col = '0;
  logic [NB-1:0] bank_ready, bank_pre;
  logic cmd_err, wr_valid, rd_valid;
  logic [1:0] wr_bank, rd_bank;
  logic [COL_W-1:0] wr_col, rd_col;

  sdram_ap_tracker #(.NUM_BANKS(NB), .COL_W(COL_W), .BL(BL), .CL(CL),
                     .T_DPL(T_DPL), .T_RP(T_RP)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_code(cmd_code), .cmd_ap(cmd_ap),
    .cmd_bank(cmd_bank), .cmd_col(cmd_col), .bank_ready(bank_ready),
    .bank_pre(bank_pre), .cmd_err(cmd_err), .wr_valid(wr_valid),
    .wr_bank(wr_bank), .wr_col(wr_col), .rd_valid(rd_valid),
    .rd_bank(rd_bank), .rd_col(rd_col));

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0;
  int p_cmd[64], p_ap[64], p_bank[64], p_col[64];
  int o_wv[64], o_wb[64], o_wc[64], o_rv[64], o_rb[64], o_rc[64], o_err[64];
  int o_rdy[4][64], o_pre[4][64];
  int e_wv[64], e_wb[64], e_wc[64], e_rv[64], e_rb[64], e_rc[64], e_err[64];
  int e_pre[4][64];
  string e_wt[64], e_rt[64], e_pt[4][64];

  function automatic int wrapc(int base, int i);
    return (base / BL) * BL + ((base % BL) + i) % BL;
  endfunction

  task automatic chk(string tag, string what, int t, int act, int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s cycle %0d: got %0d expected %0d", tag, what, t, act, exp);
    end
  endtask

  task automatic clear(string wt, string rt, string pt);
    for (int t = 0; t < 64; t++) begin
      p_cmd[t] = 0; p_ap[t] = 0; p_bank[t] = 0; p_col[t] = 0;
      e_wv[t] = 0; e_wb[t] = 0; e_wc[t] = 0; e_rv[t] = 0; e_rb[t] = 0;
      e_rc[t] = 0; e_err[t] = 0; e_wt[t] = wt; e_rt[t] = rt;
      for (int b = 0; b < NB; b++) begin e_pre[b][t] = 0; e_pt[b][t] = pt; end
    end
  endtask

  task automatic plan(int t, int c, int ap, int b, int col);
    p_cmd[t] = c; p_ap[t] = ap; p_bank[t] = b; p_col[t] = col;
  endtask

  task automatic add_wr(int b, int col, int from, int to, string tag);
    for (int t = from; t <= to; t++) begin
      e_wv[t] = 1; e_wb[t] = b; e_wc[t] = wrapc(col, t - from); e_wt[t] = tag;
    end
  endtask

  task automatic add_rd(int b, int col, int from, int to, string tag);
    for (int t = from; t <= to; t++) begin
      e_rv[t+CL] = 1; e_rb[t+CL] = b; e_rc[t+CL] = wrapc(col, t - from);
      e_rt[t+CL] = tag;
    end
  endtask

  task automatic add_pre(int b, int from, int to, string tag);
    for (int t = from - 1; t <= to + 1; t++) e_pt[b][t] = tag;
    for (int t = from; t <= to; t++) e_pre[b][t] = 1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_code = 2'd0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(int n);
    for (int t = 0; t < n; t++) begin
      @(negedge clk);
      cmd_code = 2'(p_cmd[t]); cmd_ap = 1'(p_ap[t]);
      cmd_bank = 2'(p_bank[t]); cmd_col = COL_W'(p_col[t]);
      #5;
      o_wv[t] = int'(wr_valid); o_wb[t] = int'(wr_bank); o_wc[t] = int'(wr_col);
      o_rv[t] = int'(rd_valid); o_rb[t] = int'(rd_bank); o_rc[t] = int'(rd_col);
      o_err[t] = int'(cmd_err);
      for (int b = 0; b < NB; b++) begin
        o_rdy[b][t] = int'(bank_ready[b]); o_pre[b][t] = int'(bank_pre[b]);
      end
    end
    @(negedge clk);
    cmd_code = 2'd0;
  endtask

  task automatic compare(int n);
    for (int t = 0; t < n; t++) begin
      chk(e_wt[t], "wr_valid", t, o_wv[t], e_wv[t]);
      if (e_wv[t] != 0) begin
        chk(e_wt[t], "wr_bank", t, o_wb[t], e_wb[t]);
        chk(e_wt[t], "wr_col", t, o_wc[t], e_wc[t]);
      end
      chk(e_rt[t], "rd_valid", t, o_rv[t], e_rv[t]);
      if (e_rv[t] != 0) begin
        chk(e_rt[t], "rd_bank", t, o_rb[t], e_rb[t]);
        chk(e_rt[t], "rd_col", t, o_rc[t], e_rc[t]);
      end
      chk("R2", "cmd_err", t, o_err[t], e_err[t]);
      for (int b = 0; b < NB; b++) chk(e_pt[b][t], "bank_pre", t, o_pre[b][t], e_pre[b][t]);
    end
  endtask

  // Write with AP on bank 0 at cycle 2, cut (or followed) at cycle 2+k by kind on bank 1
  task automatic interrupt_case(int kind, int k);
    int c, w0, anchor, last0, rdy0, l1;
    w0 = 2; c = w0 + k;
    clear((k < BL) ? "R4" : "R3", "R7", "R5");
    plan(0, 1, 0, 0, 0);
    plan(1, 1, 0, 1, 0);
    plan(w0, 3, 1, 0, 5);
    plan(c, kind, 1, 1, 9);
    last0  = ((c < w0 + BL) ? c : w0 + BL) - 1;
    anchor = (k < BL) ? c : last0;
    rdy0   = anchor + T_DPL + T_RP + 1;
    plan(rdy0 - 1, 1, 0, 0, 0);
    plan(rdy0, 1, 0, 0, 0);
    e_err[rdy0 - 1] = 1;
    add_wr(0, 5, w0, last0, (k < BL) ? "R4" : "R3");
    add_pre(0, anchor + T_DPL + 1, anchor + T_DPL + T_RP, "R5");
    l1 = c + BL - 1;
    if (kind == 3) begin
      add_wr(1, 9, c, l1, "R10");
      add_pre(1, l1 + T_DPL + 1, l1 + T_DPL + T_RP, "R10");
    end else begin
      add_rd(1, 9, c, l1, "R7");
      add_pre(1, l1 + 1, l1 + T_RP, "R8");
    end
    do_reset();
    run(NC);
    compare(NC);
    for (int t = 2; t <= rdy0 + 1; t++)
      chk("R6", "bank_ready0", t, o_rdy[0][t], (t == rdy0) ? 1 : 0);
    chk("R6", "early_open_flagged", rdy0 - 1, o_err[rdy0 - 1], 1);
    chk("R6", "open_on_ready_ok", rdy0, o_err[rdy0], 0);
  endtask

  task automatic directed_case();
    clear("R3", "R9", "R2");
    plan(0, 1, 0, 0, 0);
    plan(1, 2, 0, 2, 0);   e_err[1] = 1;      // read to idle bank
    plan(2, 3, 0, 0, 2);                       // write, no AP
    plan(3, 3, 0, 0, 0);   e_err[3] = 1;      // write to bursting bank: ignored
    add_wr(0, 2, 2, 5, "R3");
    plan(6, 1, 0, 0, 0);   e_err[6] = 1;      // open of a page-open bank
    plan(7, 2, 0, 0, 8);                       // bank back to page-open (R9)
    add_rd(0, 8, 7, 10, "R9");
    plan(8, 3, 0, 0, 0);   e_err[8] = 1;
    plan(12, 1, 0, 3, 0);
    plan(13, 3, 0, 0, 4);                      // write no AP, cut at 15
    add_wr(0, 4, 13, 14, "R4");
    plan(15, 2, 1, 3, 0);                      // read with AP, bank 3
    add_rd(3, 0, 15, 18, "R7");
    add_pre(3, 19, 21, "R8");
    plan(20, 2, 0, 0, 12);                     // cut bank 0 page-open again (R9)
    add_rd(0, 12, 20, 23, "R9");
    do_reset();
    run(NC);
    compare(NC);
    chk("R6", "bank_ready3", 21, o_rdy[3][21], 0);
    chk("R6", "bank_ready3", 22, o_rdy[3][22], 1);
    chk("R9", "page_open_no_err", 20, o_err[20], 0);
  endtask

  initial begin
    #(20 * 200000);
    nerr++; nchk++;
    $display("FAIL watchdog: run did not end, got 0 expected 1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    do_reset();
    #5;
    for (int b = 0; b < NB; b++) begin
      chk("R1", "bank_ready", 0, int'(bank_ready[b]), 1);
      chk("R1", "bank_pre", 0, int'(bank_pre[b]), 0);
    end
    chk("R1", "wr_valid", 0, int'(wr_valid), 0);
    chk("R1", "rd_valid", 0, int'(rd_valid), 0);
    chk("R1", "cmd_err", 0, int'(cmd_err), 0);
    for (int k = 1; k <= BL + 1; k++) begin
      interrupt_case(2, k);
      interrupt_case(3, k);
    end
    directed_case();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule